// File: doc/BRIEF.md
# SPI Master with Receive-Full Clock Stall

This block is an SPI master that moves one 8-bit frame at a time between a single transmit holding register and a single receive holding register. A host on a simple register port writes a byte to start a frame and reads the received byte back. It supports all four clock polarity and phase combinations. The SCK rate comes from a programmable divider. Three programmable gaps shape the frame: select-to-first-edge, last-edge-to-deselect, and deselect-to-next-select.

When the stall option is on and a frame reaches its final bit while the receive holding register still holds unread data, the master freezes SCK at its idle level with the select still asserted. It finishes the frame only after the host has read the pending byte, so no received data is lost and no overrun can occur. When the option is off, the master keeps clocking. A frame that completes into a full receive register is then dropped and an overrun flag is raised.

Top module: `spi_stall_master`

## Requirements
- R1: After reset, SCK is low, select is high, the status register (address 2) reads 0x01 and the data register (address 0) reads 0x00.
- R2: A write to address 0 while the transmit-empty flag (status bit 0) is 1 loads the transmit register and clears the flag. The flag returns to 1 when the byte moves into the shift register at frame start.
- R3: A write to address 0 while status bit 0 is 0 is ignored and never reaches the line.
- R4: A frame produces exactly 16 SCK transitions, all while select is low. SCK rests at the polarity level (control bit 0) whenever no frame is shifting.
- R5: Data moves MSB first in both directions. With phase (control bit 1) at 0 the master samples MISO on the first edge of each SCK cycle, and with phase at 1 on the second edge. The slave sees the written byte and the master captures the slave's byte.
- R6: The time from select falling to the first SCK edge is 2·T1·H system clocks, where T1 = delay register (address 3) bits 2:0 plus 1, and H = control bits 6:4 plus 1.
- R7: The time from the last SCK edge to select rising is 2·T2·H system clocks, where T2 = address 3 bits 6:4 plus 1.
- R8: When the next byte is already waiting, the time from select rising to the next select falling is 2·T3·H system clocks, where T3 = address 4 bits 2:0 plus 1.
- R9: With stall enabled (control bit 2) and the receive-full flag (status bit 1) set, a frame stops after 14 SCK edges. SCK stays at the polarity level and select stays low, and the overrun flag (status bit 2) is never set.
- R10: A host read of address 0 during a stall returns the pending byte and clears receive-full. The frame then completes with its received byte intact.
- R11: A completed frame sets status bit 1. A read of address 0 (with the read strobe) returns the byte and clears the bit.
- R12: With stall disabled, a frame that completes while status bit 1 is set raises status bit 2 and discards the new byte. Writing 1 to bit 2 of address 2 clears the flag.
- R13: Successive SCK edges are H system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (consumes receive data at address 0) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Active-low slave select |

## Verification
The bench targets the stall point. A design that stalls one edge late would leave SCK at the active level or lose the final bit. One that restarts early would overwrite the unread byte. It checks that overrun stays clear while stalled and that the resumed frame still delivers the right byte.

Back-to-back frames with a third write issued while the buffer is full catch a design that accepts writes into an occupied transmit register. The same frames measure the deselect gap, which an off-by-one in the delay counters would lengthen by half an SCK period.

Random frames across all four modes, dividers and delays compare both data directions and every timing span against values the bench computes. This exposes swapped sampling edges or a misplaced first bit under phase 0.

// File: rtl/spi_stall_pkg.sv
package spi_stall_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP
  } spi_state_e;

  localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_DLY  = 3'd3;
  localparam logic [ADDR_W-1:0] A_GAP  = 3'd4;

  // control / status field positions
  localparam int C_CPOL  = 0;
  localparam int C_CPHA  = 1;
  localparam int C_STALL = 2;
  localparam int C_DIV   = 4;
  localparam int S_TXE   = 0;
  localparam int S_RXF   = 1;
  localparam int S_OVR   = 2;
  localparam int S_BUSY  = 3;
  localparam int D_T1    = 0;
  localparam int D_T2    = 4;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] hdiv_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!en_i || restart_i)  cnt_q <= '0;
    else if (cnt_q == hdiv_i)     cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == hdiv_i);
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         tx_shift_i,
  input  logic         rx_sample_i,
  input  logic         miso_i,
  output logic         mosi_o,
  output logic [W-1:0] rx_word_o,
  output logic [W-1:0] rx_next_o
);
  logic [W-1:0] tx_sr_q, rx_sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr_q <= '0;
      rx_sr_q <= '0;
    end else begin
      if (load_i)          tx_sr_q <= load_data_i;
      else if (tx_shift_i) tx_sr_q <= {tx_sr_q[W-2:0], 1'b0};
      if (rx_sample_i)     rx_sr_q <= rx_next_o;
    end
  end

  assign mosi_o    = tx_sr_q[W-1];
  assign rx_word_o = rx_sr_q;
  assign rx_next_o = {rx_sr_q[W-2:0], miso_i};
endmodule

// File: rtl/spi_stall_master.sv
module spi_stall_master
  import spi_stall_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int DIV_W   = 3,
  parameter int DLY_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [FRAME_W-1:0] wdata_i,
  output logic [FRAME_W-1:0] rdata_o,
  output logic               sck_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic               cs_n_o
);
  localparam int EC_W = $clog2(2 * FRAME_W);
  localparam int DC_W = DLY_W + 1;
  localparam logic [EC_W-1:0] LAST_EDGE  = EC_W'(2 * FRAME_W - 1);
  localparam logic [EC_W-1:0] STALL_EDGE = EC_W'(2 * FRAME_W - 2);

  spi_state_e       state_q;
  logic [DC_W-1:0]  dcnt_q;
  logic [EC_W-1:0]  edge_q;
  logic             sck_q, cs_n_q;
  logic             cpol_q, cpha_q, stall_en_q;
  logic [DIV_W-1:0] hdiv_q;
  logic [DLY_W-1:0] t1_q, t2_q, t3_q;
  logic [FRAME_W-1:0] tx_buf_q, rx_buf_q;
  logic             tx_full_q, rx_full_q, ovr_q;

  logic tick, start, stall, edge_go, leading, rx_sample, tx_shift, frame_done;
  logic data_wr, data_rd, dly_done;
  logic [FRAME_W-1:0] rx_word, rx_next, frame_word;

  assign data_wr  = wr_i && (addr_i == A_DATA);
  assign data_rd  = rd_i && (addr_i == A_DATA);
  assign dly_done = tick && (dcnt_q == '0);

  assign start = tx_full_q && ((state_q == ST_IDLE) || (state_q == ST_GAP && dly_done));
  // hold just before the last leading edge: SCK is at idle level there
  assign stall = stall_en_q && rx_full_q && (state_q == ST_SHIFT) && (edge_q == STALL_EDGE);
  assign edge_go    = (state_q == ST_SHIFT) && tick && !stall;
  assign leading    = !edge_q[0];
  assign rx_sample  = edge_go && (cpha_q ? !leading : leading);
  assign tx_shift   = edge_go && (cpha_q ? (leading && edge_q != '0)
                                         : (!leading && edge_q != LAST_EDGE));
  assign frame_done = edge_go && (edge_q == LAST_EDGE);
  assign frame_word = cpha_q ? rx_next : rx_word;

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni,
    .en_i      (state_q != ST_IDLE),
    .restart_i (start),
    .hdiv_i    (hdiv_q),
    .tick_o    (tick)
  );

  spi_shift_unit #(.W(FRAME_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i      (start),
    .load_data_i (tx_buf_q),
    .tx_shift_i  (tx_shift),
    .rx_sample_i (rx_sample),
    .miso_i,
    .mosi_o,
    .rx_word_o   (rx_word),
    .rx_next_o   (rx_next)
  );

  // frame sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dcnt_q  <= '0;
      edge_q  <= '0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_LEAD;
          cs_n_q  <= 1'b0;
          dcnt_q  <= {t1_q, 1'b0};
        end
        ST_LEAD: if (tick) begin
          if (dcnt_q == '0) begin
            state_q <= ST_SHIFT;
            edge_q  <= '0;
          end else dcnt_q <= dcnt_q - 1'b1;
        end
        ST_SHIFT: if (edge_go) begin
          sck_q  <= ~sck_q;
          edge_q <= edge_q + 1'b1;
          if (edge_q == LAST_EDGE) begin
            state_q <= ST_TRAIL;
            dcnt_q  <= {t2_q, 1'b1};
          end
        end
        ST_TRAIL: if (tick) begin
          if (dcnt_q == '0) begin
            state_q <= ST_GAP;
            cs_n_q  <= 1'b1;
            dcnt_q  <= {t3_q, 1'b1};
          end else dcnt_q <= dcnt_q - 1'b1;
        end
        ST_GAP: begin
          if (start) begin
            state_q <= ST_LEAD;
            cs_n_q  <= 1'b0;
            dcnt_q  <= {t1_q, 1'b0};
          end else if (dly_done) state_q <= ST_IDLE;
          else if (tick)         dcnt_q  <= dcnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // host registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpol_q <= 1'b0; cpha_q <= 1'b0; stall_en_q <= 1'b0;
      hdiv_q <= '0; t1_q <= '0; t2_q <= '0; t3_q <= '0;
      tx_buf_q <= '0; tx_full_q <= 1'b0;
      rx_buf_q <= '0; rx_full_q <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_CTRL) begin
        cpol_q     <= wdata_i[C_CPOL];
        cpha_q     <= wdata_i[C_CPHA];
        stall_en_q <= wdata_i[C_STALL];
        hdiv_q     <= wdata_i[C_DIV +: DIV_W];
      end
      if (wr_i && addr_i == A_DLY) begin
        t1_q <= wdata_i[D_T1 +: DLY_W];
        t2_q <= wdata_i[D_T2 +: DLY_W];
      end
      if (wr_i && addr_i == A_GAP) t3_q <= wdata_i[0 +: DLY_W];

      if (start) tx_full_q <= 1'b0;
      else if (data_wr && !tx_full_q) begin
        tx_buf_q  <= wdata_i;
        tx_full_q <= 1'b1;
      end

      if (frame_done && !rx_full_q) begin
        rx_buf_q  <= frame_word;
        rx_full_q <= 1'b1;
      end else if (data_rd) rx_full_q <= 1'b0;

      if (frame_done && rx_full_q) ovr_q <= 1'b1;
      else if (wr_i && addr_i == A_STAT && wdata_i[S_OVR]) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_DATA: rdata_o = rx_buf_q;
      A_CTRL: begin
        rdata_o[C_CPOL]  = cpol_q;
        rdata_o[C_CPHA]  = cpha_q;
        rdata_o[C_STALL] = stall_en_q;
        rdata_o[C_DIV +: DIV_W] = hdiv_q;
      end
      A_STAT: begin
        rdata_o[S_TXE]  = !tx_full_q;
        rdata_o[S_RXF]  = rx_full_q;
        rdata_o[S_OVR]  = ovr_q;
        rdata_o[S_BUSY] = (state_q != ST_IDLE);
      end
      A_DLY: begin
        rdata_o[D_T1 +: DLY_W] = t1_q;
        rdata_o[D_T2 +: DLY_W] = t2_q;
      end
      A_GAP:   rdata_o[0 +: DLY_W] = t3_q;
      default: rdata_o = '0;
    endcase
  end

  assign sck_o  = sck_q ^ cpol_q;
  assign cs_n_o = cs_n_q;

  assert_no_ovr_in_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_en_q && !ovr_q) |=> !ovr_q);
  assert_stall_sck_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |-> (sck_q == 1'b0 && !cs_n_q));
  assert_sck_quiet_deselected_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_q |-> (sck_q == 1'b0));
  assert_tx_empty_after_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !tx_full_q);
  assert_rx_full_after_frame_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && !rx_full_q) |=> rx_full_q);
endmodule

// File: tb/spi_stall_master_test.sv
module spi_stall_master_test;
  import spi_stall_pkg::*;
  localparam int PER = 4;  // 250 MHz: 4 time units per cycle

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0, miso = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       sck, mosi, cs_n;

  spi_stall_master uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .cs_n_o(cs_n)
  );

  int n_chk = 0, n_err = 0;
  logic b_cpol = 1'b0, b_cpha = 1'b0;

  // slave model
  logic [7:0] s_sr = '0, s_rx = '0, s_tx_next = '0;
  int  edges = 0;
  time t_fall = 0, t_first = 0, t_e2 = 0, t_last = 0, t_rise = 0;
  logic cs_prev = 1'b1, sck_prev = 1'b0, s_lead;

  always @(cs_n or sck) begin
    if (cs_n !== cs_prev) begin
      cs_prev  = cs_n;
      sck_prev = sck;
      if (!cs_n) begin
        s_sr   = s_tx_next;
        edges  = 0;
        t_fall = $time;
        if (!b_cpha) miso = s_sr[7];
      end else t_rise = $time;
    end else if (sck !== sck_prev) begin
      sck_prev = sck;
      if (!cs_n && rst_n) begin
        edges++;
        if (edges == 1) t_first = $time;
        if (edges == 2) t_e2 = $time;
        t_last = $time;
        s_lead = (sck != b_cpol);
        if (s_lead != b_cpha) s_rx = {s_rx[6:0], mosi};
        else if (b_cpha) begin
          miso = s_sr[7];
          s_sr = {s_sr[6:0], 1'b0};
        end else begin
          s_sr = {s_sr[6:0], 1'b0};
          miso = s_sr[7];
        end
      end
    end
  end

  function automatic longint exp_span(input int t, input int h);
    return longint'(2 * t * h);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = (a == A_DATA);
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    #1 d = rdata;
  endtask

  task automatic set_cfg(input logic cpol, input logic cpha, input logic stall,
                         input int h, input int t1, input int t2, input int t3);
    host_wr(A_CTRL, {1'b0, 3'(h - 1), 1'b0, stall, cpha, cpol});
    host_wr(A_DLY, {1'b0, 3'(t2 - 1), 1'b0, 3'(t1 - 1)});
    host_wr(A_GAP, {5'b0, 3'(t3 - 1)});
    b_cpol = cpol;
    b_cpha = cpha;
  endtask

  task automatic run_frame(input logic [7:0] mo, input logic [7:0] so, input int t1,
                           input int t2, input int h, input bit do_read);
    logic [7:0] d;
    s_tx_next = so;
    host_wr(A_DATA, mo);
    @(posedge cs_n); @(negedge clk);
    chk("R5 slave got master byte", s_rx, mo);
    chk("R4 edge count", edges, 16);
    chk("R4 idle level", sck, b_cpol);
    chk("R6 select-to-clock", longint'((t_first - t_fall) / PER), exp_span(t1, h));
    chk("R7 clock-to-deselect", longint'((t_rise - t_last) / PER), exp_span(t2, h));
    chk("R13 half period", longint'((t_e2 - t_first) / PER), h);
    if (do_read) begin
      host_rd(A_DATA, d);
      chk("R5 R11 master got slave byte", d, so);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(A_STAT, d); chk("R1 status", d, 8'h01);
    peek(A_DATA, d); chk("R1 data", d, 8'h00);
    chk("R1 sck", sck, 0);
    chk("R1 select", cs_n, 1);

    // R11 basic frame and receive flag
    set_cfg(1'b0, 1'b0, 1'b0, 2, 1, 1, 1);
    run_frame(8'hA5, 8'h3C, 1, 1, 2, 1'b0);
    peek(A_STAT, d); chk("R11 rx full set", d[S_RXF], 1);
    host_rd(A_DATA, d); chk("R11 rx data", d, 8'h3C);
    peek(A_STAT, d); chk("R11 rx full cleared", d[S_RXF], 0);

    // R2 R3 R8 back-to-back frames, third write ignored
    set_cfg(1'b1, 1'b0, 1'b0, 2, 2, 2, 3);
    s_tx_next = 8'h11;
    host_wr(A_DATA, 8'h5A);
    @(negedge cs_n); @(negedge clk);
    peek(A_STAT, d); chk("R2 tx empty after load", d[S_TXE], 1);
    s_tx_next = 8'h22;
    host_wr(A_DATA, 8'hC3);
    peek(A_STAT, d); chk("R2 tx empty cleared", d[S_TXE], 0);
    host_wr(A_DATA, 8'hFF);
    @(posedge cs_n); @(negedge clk);
    chk("R5 first byte", s_rx, 8'h5A);
    host_rd(A_DATA, d); chk("R11 first rx", d, 8'h11);
    @(negedge cs_n); @(negedge clk);
    chk("R8 deselect gap", longint'((t_fall - t_rise) / PER), exp_span(3, 2));
    @(posedge cs_n); @(negedge clk);
    chk("R3 second byte not overwritten", s_rx, 8'hC3);
    host_rd(A_DATA, d); chk("R11 second rx", d, 8'h22);
    repeat (100) @(negedge clk);
    peek(A_STAT, d);
    chk("R3 no extra frame", d[S_BUSY], 0);
    chk("R3 tx empty", d[S_TXE], 1);

    // R9 R10 stall while receive full
    set_cfg(1'b1, 1'b1, 1'b1, 1, 1, 2, 1);
    run_frame(8'h96, 8'h69, 1, 2, 1, 1'b0);
    s_tx_next = 8'hE1;
    host_wr(A_DATA, 8'h1E);
    wait (edges == 14 && !cs_n);
    repeat (40) @(negedge clk);
    chk("R9 edges frozen", edges, 14);
    chk("R9 sck idle", sck, 1);
    chk("R9 select held", cs_n, 0);
    peek(A_STAT, d);
    chk("R9 no overrun", d[S_OVR], 0);
    chk("R9 rx still full", d[S_RXF], 1);
    host_rd(A_DATA, d); chk("R10 pending byte", d, 8'h69);
    @(posedge cs_n); @(negedge clk);
    chk("R10 frame resumed", edges, 16);
    chk("R10 slave byte", s_rx, 8'h1E);
    peek(A_STAT, d); chk("R9 overrun clear", d[S_OVR], 0);
    host_rd(A_DATA, d); chk("R10 resumed rx", d, 8'hE1);

    // R12 overrun with stall off
    set_cfg(1'b0, 1'b1, 1'b0, 3, 1, 1, 1);
    run_frame(8'h0F, 8'hF0, 1, 1, 3, 1'b0);
    run_frame(8'h33, 8'hCC, 1, 1, 3, 1'b0);
    peek(A_STAT, d);
    chk("R12 overrun set", d[S_OVR], 1);
    chk("R12 rx full", d[S_RXF], 1);
    host_rd(A_DATA, d); chk("R12 old byte kept", d, 8'hF0);
    host_wr(A_STAT, 8'h04);
    peek(A_STAT, d); chk("R12 overrun cleared", d[S_OVR], 0);

    // random modes, dividers, delays
    for (int i = 0; i < 12; i++) begin
      automatic logic cp = 1'($urandom);
      automatic logic ch = 1'($urandom);
      automatic int h  = int'($urandom_range(1, 8));
      automatic int t1 = int'($urandom_range(1, 8));
      automatic int t2 = int'($urandom_range(1, 8));
      automatic int t3 = int'($urandom_range(1, 8));
      set_cfg(cp, ch, 1'($urandom), h, t1, t2, t3);
      run_frame(8'($urandom), 8'($urandom), t1, t2, h, 1'b1);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule